// File: doc/BRIEF.md
# External Interrupt Edge Capture

This block turns four asynchronous external request lines into latched interrupt flags. Each line first passes through a multi-flop synchronizer. Its edges are then found by comparing the newest synchronized sample with the one before it. A per-line edge selection decides which transitions set the line's flag. Lane 0 has a four-way selection: rising, falling, both, or blocked. Lanes 1 and 2 each choose between rising and falling. Lane 3 always reacts to both edges.

Three small mode registers set the edge selection. They are loaded through a narrow register write port made of an address, a data nibble and a strobe, and each one is read back on its own output. Lanes 0, 1 and 3 drop their flags on a one-cycle acknowledge pulse from the interrupt controller. Lane 2 is a software-managed request: acknowledge does not touch it, and only a dedicated clear input drops it. Priority, vectoring and global enable are handled outside this block.

Top module: `ext_irq_edge_ctrl`

## Requirements
- R1: After reset all four flags on `irq_o` are 0 and all three mode readbacks are 0, so every configurable lane starts on rising-edge detection.
- R2: Lane 0 uses mode bits [1:0]: 00 sets the flag on a rising edge, 01 on a falling edge, 10 on either edge, and 11 never sets the flag.
- R3: Lanes 1 and 2 use mode bit 0 only: 0 sets the flag on a rising edge and 1 on a falling edge.
- R4: Lane 3 sets its flag on every rising and every falling edge of its pin, whatever the mode registers hold.
- R5: A pin level that is present at clock edge k causes its flag to be visible after clock edge k+SYNC_STAGES, and not before.
- R6: For lanes 0, 1 and 3, an `ack_i` bit that is high at a clock edge clears that flag at that edge. If a qualifying edge is detected in the same cycle, the flag stays set.
- R7: The lane 2 flag ignores `ack_i[2]`. It clears only when `irq2_clr_i` is high at a clock edge, and a simultaneous qualifying edge keeps it set.
- R8: A write with `wr_en_i` high loads the mode register at address 0xFCF (lane 0), 0xFB4 (lane 1) or 0xFB5 (lane 2) at that clock edge, and the new mode governs edge detection from then on. Writes to any other address change nothing.
- R9: Mode bits above the used ones (bits [3:2] of lane 0 and bits [3:1] of lanes 1 and 2) read back as 0 and ignore written ones.
- R10: Changing a mode register while a pin is held steady never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 4 | Asynchronous request lines, lanes 0 to 3 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| ack_i | input | 4 | Acknowledge pulses; bit 2 has no effect |
| irq2_clr_i | input | 1 | Software clear for the lane 2 flag |
| irq_o | output | 4 | Latched request flags, lanes 0 to 3 |
| mode0_o | output | DATA_W | Lane 0 mode readback |
| mode1_o | output | DATA_W | Lane 1 mode readback |
| mode2_o | output | DATA_W | Lane 2 mode readback |

## Verification
The bench builds the block with its defaults: SYNC_STAGES of 2, a 12-bit address and a 4-bit data nibble. With only two synchronizer flops, the latency window is short enough that directed pulses can place an acknowledge or software clear in exactly the cycle a new edge is detected. This exercises the set-over-clear priority on lanes 3 and 2. The full 4-bit data width lets the bench write ones into the unused mode bits and check that they are dropped. A long randomized phase mixes pin toggles, acknowledges and mode writes, with a cycle-accurate reference model tracking each lane.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   // Edge selection applied inside one lane
   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_OFF  = 2'b11
   } edge_sel_e;

   localparam int unsigned NUM_LANES  = 4;
   localparam int unsigned QUASI_LANE = 2;
   localparam int unsigned FIXED_LANE = 3;

   // One-bit rising/falling choice used by the two-way lanes
   function automatic edge_sel_e two_way_sel(input logic fall_bit);
      return fall_bit ? EDGE_FALL : EDGE_RISE;
   endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic cur_o,
   output logic prev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ext_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign cur_o  = chain_q[STAGES-1];
   assign prev_o = prev_q;

endmodule

// File: rtl/ext_irq_lane.sv
module ext_irq_lane
   import ext_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_i,
   input  edge_sel_e sel_i,
   input  logic      clr_i,
   output logic      flag_o,
   output logic      req_o
);

   logic cur, prev, rise, fall, req, flag_q;

   ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pin_i),
      .cur_o  (cur),
      .prev_o (prev)
   );

   assign rise = cur & ~prev;
   assign fall = ~cur & prev;

   always_comb begin
      unique case (sel_i)
         EDGE_RISE: req = rise;
         EDGE_FALL: req = fall;
         EDGE_BOTH: req = rise | fall;
         default:   req = 1'b0;
      endcase
   end

   // A detected edge outranks a clear arriving in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= req | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;
   assign req_o  = req;

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && clr_i) |=> flag_o);

   assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (cur != prev));

endmodule

// File: rtl/ext_irq_mode_regs.sv
module ext_irq_mode_regs #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 4,
   parameter logic [ADDR_W-1:0] ADDR_MODE0 = 12'hFCF,
   parameter logic [ADDR_W-1:0] ADDR_MODE1 = 12'hFB4,
   parameter logic [ADDR_W-1:0] ADDR_MODE2 = 12'hFB5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [1:0]        mode0_q_o,
   output logic              mode1_q_o,
   output logic              mode2_q_o,
   output logic [DATA_W-1:0] mode0_rd_o,
   output logic [DATA_W-1:0] mode1_rd_o,
   output logic [DATA_W-1:0] mode2_rd_o
);

   if (DATA_W < 3) begin : g_bad_width
      $error("ext_irq_mode_regs: DATA_W must be at least 3");
   end
   if (ADDR_MODE0 == ADDR_MODE1 || ADDR_MODE0 == ADDR_MODE2 ||
       ADDR_MODE1 == ADDR_MODE2) begin : g_bad_addr
      $error("ext_irq_mode_regs: mode addresses must differ");
   end

   logic [1:0] m0_q;
   logic       m1_q, m2_q;
   logic       hit0, hit1, hit2;
   logic       unused_data_hi;

   assign hit0 = wr_en_i && (wr_addr_i == ADDR_MODE0);
   assign hit1 = wr_en_i && (wr_addr_i == ADDR_MODE1);
   assign hit2 = wr_en_i && (wr_addr_i == ADDR_MODE2);
   assign unused_data_hi = ^wr_data_i[DATA_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m0_q <= 2'b00;
         m1_q <= 1'b0;
         m2_q <= 1'b0;
      end else begin
         if (hit0) m0_q <= wr_data_i[1:0];
         if (hit1) m1_q <= wr_data_i[0];
         if (hit2) m2_q <= wr_data_i[0];
      end
   end

   assign mode0_q_o  = m0_q;
   assign mode1_q_o  = m1_q;
   assign mode2_q_o  = m2_q;
   assign mode0_rd_o = DATA_W'(m0_q);
   assign mode1_rd_o = DATA_W'(m1_q);
   assign mode2_rd_o = DATA_W'(m2_q);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ($stable(m0_q) && $stable(m1_q) && $stable(m2_q)));

endmodule

// File: rtl/ext_irq_edge_ctrl.sv
module ext_irq_edge_ctrl
   import ext_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 4,
   parameter logic [ADDR_W-1:0] ADDR_MODE0 = 12'hFCF,
   parameter logic [ADDR_W-1:0] ADDR_MODE1 = 12'hFB4,
   parameter logic [ADDR_W-1:0] ADDR_MODE2 = 12'hFB5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        ext_pin_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [3:0]        ack_i,
   input  logic              irq2_clr_i,
   output logic [3:0]        irq_o,
   output logic [DATA_W-1:0] mode0_o,
   output logic [DATA_W-1:0] mode1_o,
   output logic [DATA_W-1:0] mode2_o
);

   logic [1:0]           mode0_q;
   logic                 mode1_q, mode2_q;
   edge_sel_e            lane_sel [NUM_LANES];
   logic [NUM_LANES-1:0] lane_clr;
   logic [NUM_LANES-1:0] lane_req;
   logic [NUM_LANES-1:0] lane_flag;
   logic                 unused_ack_quasi;

   ext_irq_mode_regs #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .ADDR_MODE0 (ADDR_MODE0),
      .ADDR_MODE1 (ADDR_MODE1),
      .ADDR_MODE2 (ADDR_MODE2)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .mode0_q_o  (mode0_q),
      .mode1_q_o  (mode1_q),
      .mode2_q_o  (mode2_q),
      .mode0_rd_o (mode0_o),
      .mode1_rd_o (mode1_o),
      .mode2_rd_o (mode2_o)
   );

   assign unused_ack_quasi = ack_i[QUASI_LANE];

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      if (i == 0) begin : g_sel
         assign lane_sel[i] = edge_sel_e'(mode0_q);
      end else if (i == 1) begin : g_sel
         assign lane_sel[i] = two_way_sel(mode1_q);
      end else if (i == QUASI_LANE) begin : g_sel
         assign lane_sel[i] = two_way_sel(mode2_q);
      end else begin : g_sel
         assign lane_sel[i] = EDGE_BOTH;
      end

      if (i == QUASI_LANE) begin : g_clr
         assign lane_clr[i] = irq2_clr_i;
      end else begin : g_clr
         assign lane_clr[i] = ack_i[i];
      end

      ext_irq_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (ext_pin_i[i]),
         .sel_i  (lane_sel[i]),
         .clr_i  (lane_clr[i]),
         .flag_o (lane_flag[i]),
         .req_o  (lane_req[i])
      );
   end

   assign irq_o = lane_flag;

   assert_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[0]) |-> ($past(mode0_q) != 2'b11));

   assert_quasi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[QUASI_LANE] && !irq2_clr_i) |=> irq_o[QUASI_LANE]);

   assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[0] && !lane_req[0]) |=> !irq_o[0]);

   assert_fixed_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_req[FIXED_LANE] |=> irq_o[FIXED_LANE]);

endmodule

// File: tb/ext_irq_edge_ctrl_tb.sv
module ext_irq_edge_ctrl_tb;

   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pins = '0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [3:0]  wr_data = '0;
   logic [3:0]  ack = '0;
   logic        clr2 = 1'b0;
   logic [3:0]  irq;
   logic [3:0]  rd0, rd1, rd2;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ext_irq_edge_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin_i(pins), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
      .irq2_clr_i(clr2), .irq_o(irq), .mode0_o(rd0), .mode1_o(rd1),
      .mode2_o(rd2)
   );

   // ---------------- reference model and scoreboard ----------------
   logic [3:0]  hist [0:SYNC];
   logic [3:0]  mf;
   logic [1:0]  m0;
   logic        m1, m2;
   logic [15:0] exp_q [$];

   always @(posedge clk or negedge rst_n) begin
      logic [3:0] s, p, rise, fall, set, clr;
      if (!rst_n) begin
         for (int i = 0; i <= SYNC; i++) hist[i] = '0;
         mf = '0; m0 = '0; m1 = 1'b0; m2 = 1'b0;
      end else begin
         s = hist[SYNC-1]; p = hist[SYNC];
         rise = s & ~p; fall = ~s & p;
         case (m0)
            2'd0: set[0] = rise[0];
            2'd1: set[0] = fall[0];
            2'd2: set[0] = rise[0] | fall[0];
            default: set[0] = 1'b0;
         endcase
         set[1] = m1 ? fall[1] : rise[1];
         set[2] = m2 ? fall[2] : rise[2];
         set[3] = rise[3] | fall[3];
         clr = {ack[3], clr2, ack[1], ack[0]};
         mf = set | (mf & ~clr);
         if (wr_en && wr_addr == 12'hFCF) m0 = wr_data[1:0];
         if (wr_en && wr_addr == 12'hFB4) m1 = wr_data[0];
         if (wr_en && wr_addr == 12'hFB5) m2 = wr_data[0];
         for (int i = SYNC; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = pins;
         exp_q.push_back({mf, 2'b00, m0, 3'b000, m1, 3'b000, m2});
      end
   end

   task automatic sb_cmp(string tag, logic [3:0] got, logic [3:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s scoreboard: got %h expected %h", tag, got, exp);
      end
   endtask

   always @(negedge clk) begin
      logic [15:0] e;
      if (rst_n && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         sb_cmp("R2 lane0", {3'b0, irq[0]}, {3'b0, e[12]});
         sb_cmp("R3 lane1/2", {2'b0, irq[2:1]}, {2'b0, e[14:13]});
         sb_cmp("R4 lane3", {3'b0, irq[3]}, {3'b0, e[15]});
         sb_cmp("R8 mode0", rd0, e[11:8]);
         sb_cmp("R8 mode1", rd1, e[7:4]);
         sb_cmp("R8 mode2", rd2, e[3:0]);
      end
   end

   // ---------------- directed helpers ----------------
   task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [3:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 flags", irq, 4'h0);
      chk("R1 mode0", rd0, 4'h0);
      chk("R1 mode1", rd1, 4'h0);
      chk("R1 mode2", rd2, 4'h0);

      // R5 latency on lane 1, rising edge
      pins[1] = 1'b1;
      tick(SYNC);
      chk("R5 before", {3'b0, irq[1]}, 4'h0);
      tick();
      chk("R5 at", {3'b0, irq[1]}, 4'h1);

      // R6 acknowledge clears lane 1
      ack[1] = 1'b1; tick(); ack[1] = 1'b0;
      chk("R6 ack clear", {3'b0, irq[1]}, 4'h0);

      // R3 falling mode on lane 1
      wr(12'hFB4, 4'h1);
      pins[1] = 1'b0; tick(SYNC + 1);
      chk("R3 lane1 fall", {3'b0, irq[1]}, 4'h1);
      ack[1] = 1'b1; tick(); ack[1] = 1'b0;

      // R2 blocked mode, then R10 mode changes with pin steady
      wr(12'hFCF, 4'h3);
      pins[0] = 1'b1; tick(SYNC + 2);
      chk("R2 blocked", {3'b0, irq[0]}, 4'h0);
      wr(12'hFCF, 4'h0); tick();
      wr(12'hFCF, 4'h1); tick();
      wr(12'hFCF, 4'h2); tick(SYNC + 1);
      chk("R10 no spurious", {3'b0, irq[0]}, 4'h0);
      pins[0] = 1'b0; tick(SYNC + 1);
      chk("R2 both falling", {3'b0, irq[0]}, 4'h1);
      ack[0] = 1'b1; tick(); ack[0] = 1'b0;

      // R9 unused bits dropped
      wr(12'hFCF, 4'hD);
      chk("R9 mode0", rd0, 4'h1);
      wr(12'hFB5, 4'hE);
      chk("R9 mode2", rd2, 4'h0);

      // R8 foreign address ignored
      wr(12'hFB6, 4'hF);
      chk("R8 foreign0", rd0, 4'h1);
      chk("R8 foreign1", rd1, 4'h1);
      chk("R8 foreign2", rd2, 4'h0);

      // R7 lane 2 ignores ack, clears on software clear
      pins[2] = 1'b1; tick(SYNC + 1);
      chk("R7 set", {3'b0, irq[2]}, 4'h1);
      ack[2] = 1'b1; tick(); ack[2] = 1'b0;
      chk("R7 ack ignored", {3'b0, irq[2]}, 4'h1);
      clr2 = 1'b1; tick(); clr2 = 1'b0;
      chk("R7 sw clear", {3'b0, irq[2]}, 4'h0);

      // R4 lane 3 both edges; R6 set beats ack in the same cycle
      pins[3] = 1'b1; tick(SYNC + 1);
      chk("R4 rise", {3'b0, irq[3]}, 4'h1);
      pins[3] = 1'b0; tick(SYNC);
      ack[3] = 1'b1; tick(); ack[3] = 1'b0;
      chk("R6 set wins", {3'b0, irq[3]}, 4'h1);
      ack[3] = 1'b1; tick(); ack[3] = 1'b0;
      chk("R4 cleared", {3'b0, irq[3]}, 4'h0);

      // R7 set beats software clear
      pins[2] = 1'b0; tick(); pins[2] = 1'b1; tick(SYNC);
      clr2 = 1'b1; tick(); clr2 = 1'b0;
      chk("R7 set wins", {3'b0, irq[2]}, 4'h1);

      // randomized mix checked by the scoreboard
      for (int c = 0; c < 3000; c++) begin
         pins  = pins ^ 4'($urandom_range(0, 15) & $urandom_range(0, 15));
         ack   = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
         clr2  = ($urandom_range(0, 7) == 0);
         wr_en = ($urandom_range(0, 9) == 0);
         case ($urandom_range(0, 3))
            0: wr_addr = 12'hFCF;
            1: wr_addr = 12'hFB4;
            2: wr_addr = 12'hFB5;
            default: wr_addr = 12'($urandom_range(0, 4095));
         endcase
         wr_data = 4'($urandom_range(0, 15));
         tick();
      end
      wr_en = 1'b0; ack = '0; clr2 = 1'b0;
      tick(SYNC + 2);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule